// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block is the bypass and interlock control for an in-order five-stage integer pipeline. For the instruction in the execute stage it picks each of the two source operands from one of three places: the register-file value carried in the decode/execute register, the ALU result in the execute/memory register, or the result in the memory/writeback register. That last result may be either an ALU result or loaded data. The forwarded first operand also feeds a zero detector that resolves branches in execute. The forwarded second operand is the store data that the pipeline carries into the memory stage. There, a second selector can replace the store data with the value a load is writing back on the same cycle. This lets a load feed the very next store's data with no wait.

When a load sits in execute and the instruction in decode needs its result, the block raises a hold, which freezes the PC and the fetch/decode register. In the same cycle it raises a kill, which clears the control fields loaded into the decode/execute register, so exactly one no-op enters execute. There is one exception: when the only dependence of a store is its data operand, the load is let through with no stall, because the memory-stage selector repairs the store data a cycle later. A registered flag reports that execute holds such an inserted no-op. The register file writes before it reads, so a writeback result needs no path to decode.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When the execute/memory stage writes a nonzero register that equals an execute source index and is not a load, that source's operand equals the execute/memory ALU result.
- R2: When only the memory/writeback stage writes a nonzero register matching a source index, the operand equals the loaded data if that stage is a load, else its ALU result.
- R3: When both later stages write the same matching register, the execute/memory stage decides. If it is a load, the operand keeps the register-file value and the older memory/writeback value is not used.
- R4: A source index of 0 always yields the register-file value, even when a stage writes register 0.
- R5: A stage whose write enable is low never supplies a forwarded value, even when its destination index matches.
- R6: zt_zero is 1 exactly when the forwarded first operand is all zeros.
- R7: When the execute stage holds a load with write enable set, a nonzero destination, and a destination equal to a decode source whose use flag is 1, hold and kill are both 1 in that cycle. Otherwise they are 0.
- R8: A decode store (id_store=1) whose only match against that load is its second source (the data operand) causes no hold. A match on its first source (the address) still holds.
- R9: When the memory stage is a store (mem_store=1) and the writeback stage is a load that writes a nonzero register equal to mem_rs2, st_data equals wb_ldata. Otherwise st_data equals mem_sdata.
- R10: A load in the execute/memory or memory/writeback stage never raises hold, whatever the decode sources are.
- R11: ex_bubble is 0 after reset and equals, on each cycle, the value that hold had on the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | RIDX | Decode first source index |
| id_rs2 | input | RIDX | Decode second source index |
| id_use1 | input | 1 | Decode instruction reads its first source |
| id_use2 | input | 1 | Decode instruction reads its second source |
| id_store | input | 1 | Decode instruction is a store (second source is store data) |
| ex_rs1 | input | RIDX | Execute first source index |
| ex_rs2 | input | RIDX | Execute second source index |
| ex_rd | input | RIDX | Execute destination index |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_a | input | XLEN | Register-file value of first source |
| ex_b | input | XLEN | Register-file value of second source |
| mem_rs2 | input | RIDX | Memory-stage store data source index |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_rd | input | RIDX | Execute/memory destination index |
| mem_wen | input | 1 | Execute/memory writes a register |
| mem_load | input | 1 | Execute/memory is a load |
| mem_alu | input | XLEN | Execute/memory ALU result |
| mem_sdata | input | XLEN | Store data carried in execute/memory |
| wb_rd | input | RIDX | Memory/writeback destination index |
| wb_wen | input | 1 | Memory/writeback writes a register |
| wb_load | input | 1 | Memory/writeback is a load |
| wb_alu | input | XLEN | Memory/writeback ALU result |
| wb_ldata | input | XLEN | Memory/writeback loaded data |
| opnd_a | output | XLEN | Forwarded first ALU operand |
| opnd_b | output | XLEN | Forwarded second operand / store data |
| zt_zero | output | 1 | Forwarded first operand is zero |
| st_data | output | XLEN | Data-memory write data |
| hold | output | 1 | Freeze PC and fetch/decode register |
| kill | output | 1 | Clear control fields entering decode/execute |
| ex_bubble | output | 1 | Execute currently holds an inserted no-op |

## Verification
The assertions assume that the stage inputs describe a real pipeline. In particular, the cycle after a hold, the execute stage carries the no-op: its write enable is low, so no second hold can follow. The bench keeps to this: every stall vector is followed by a vector whose execute fields are idle, with the stalled load moved on to the memory stage. Each vector sets only the fields of the case under test and leaves all other stages idle with write enables low. This keeps the index-match conditions unambiguous.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_EXM = 2'd1,
    SRC_WB  = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RIDX-1:0] rs,
  input  logic [XLEN-1:0] reg_val,
  input  logic [RIDX-1:0] mem_rd,
  input  logic            mem_wen,
  input  logic            mem_load,
  input  logic [XLEN-1:0] mem_alu,
  input  logic [RIDX-1:0] wb_rd,
  input  logic            wb_wen,
  input  logic            wb_load,
  input  logic [XLEN-1:0] wb_alu,
  input  logic [XLEN-1:0] wb_ldata,
  output logic [XLEN-1:0] val
);
  logic     mem_hit, wb_hit;
  fwd_src_e src;

  always_comb begin
    mem_hit = mem_wen && (mem_rd == rs) && (rs != '0);
    wb_hit  = wb_wen && (wb_rd == rs) && (rs != '0);
    if (mem_hit)     src = mem_load ? SRC_REG : SRC_EXM;
    else if (wb_hit) src = SRC_WB;
    else             src = SRC_REG;
  end

  always_comb begin
    case (src)
      SRC_EXM: val = mem_alu;
      SRC_WB:  val = wb_load ? wb_ldata : wb_alu;
      default: val = reg_val;
    endcase
  end

  // R4
  r0_never_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (rs == '0) |-> (val == reg_val));
  // R3
  young_first_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wen && !mem_load && mem_rd == rs && rs != '0) |-> (val == mem_alu));
  // R5
  wen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_wen && !wb_wen) |-> (val == reg_val));
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mem_store,
  input  logic [RIDX-1:0] mem_rs2,
  input  logic [XLEN-1:0] mem_sdata,
  input  logic [RIDX-1:0] wb_rd,
  input  logic            wb_wen,
  input  logic            wb_load,
  input  logic [XLEN-1:0] wb_ldata,
  output logic [XLEN-1:0] st_data
);
  logic ld_to_st;

  always_comb begin
    ld_to_st = mem_store && wb_load && wb_wen && (wb_rd == mem_rs2) && (mem_rs2 != '0);
    st_data  = ld_to_st ? wb_ldata : mem_sdata;
  end

  // R9
  mem_to_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_store && wb_load && wb_wen && wb_rd == mem_rs2 && mem_rs2 != '0) |-> (st_data == wb_ldata));
  // R9
  no_store_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_store) |-> (st_data == mem_sdata));
endmodule

// File: rtl/fwd_loaduse_det.sv
module fwd_loaduse_det #(
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RIDX-1:0] id_rs1,
  input  logic [RIDX-1:0] id_rs2,
  input  logic            id_use1,
  input  logic            id_use2,
  input  logic            id_store,
  input  logic [RIDX-1:0] ex_rd,
  input  logic            ex_wen,
  input  logic            ex_load,
  output logic            hazard
);
  logic ld_live, hit1, hit2;

  always_comb begin
    ld_live = ex_load && ex_wen && (ex_rd != '0);
    hit1    = id_use1 && (id_rs1 == ex_rd);
    hit2    = id_use2 && (id_rs2 == ex_rd) && !id_store;
    hazard  = ld_live && (hit1 || hit2);
  end

  // R10
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!ex_load) |-> !hazard);
  // R8
  store_data_exempt_chk: assert property (@(posedge clk) disable iff (rst)
    (id_store && !id_use1) |-> !hazard);
  // R7
  load_use_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_load && ex_wen && ex_rd != '0 && id_use1 && id_rs1 == ex_rd) |-> hazard);
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RIDX-1:0] id_rs1,
  input  logic [RIDX-1:0] id_rs2,
  input  logic            id_use1,
  input  logic            id_use2,
  input  logic            id_store,
  input  logic [RIDX-1:0] ex_rs1,
  input  logic [RIDX-1:0] ex_rs2,
  input  logic [RIDX-1:0] ex_rd,
  input  logic            ex_wen,
  input  logic            ex_load,
  input  logic [XLEN-1:0] ex_a,
  input  logic [XLEN-1:0] ex_b,
  input  logic [RIDX-1:0] mem_rs2,
  input  logic            mem_store,
  input  logic [RIDX-1:0] mem_rd,
  input  logic            mem_wen,
  input  logic            mem_load,
  input  logic [XLEN-1:0] mem_alu,
  input  logic [XLEN-1:0] mem_sdata,
  input  logic [RIDX-1:0] wb_rd,
  input  logic            wb_wen,
  input  logic            wb_load,
  input  logic [XLEN-1:0] wb_alu,
  input  logic [XLEN-1:0] wb_ldata,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic            zt_zero,
  output logic [XLEN-1:0] st_data,
  output logic            hold,
  output logic            kill,
  output logic            ex_bubble
);
  localparam int NOPND = 2;

  logic [NOPND-1:0][RIDX-1:0] src_idx;
  logic [NOPND-1:0][XLEN-1:0] src_reg;
  logic [NOPND-1:0][XLEN-1:0] src_out;
  logic                       hazard;

  assign src_idx[0] = ex_rs1;
  assign src_idx[1] = ex_rs2;
  assign src_reg[0] = ex_a;
  assign src_reg[1] = ex_b;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fwd_operand_sel #(.XLEN(XLEN), .RIDX(RIDX)) u_sel (
      .clk(clk), .rst(rst),
      .rs(src_idx[g]), .reg_val(src_reg[g]),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load), .mem_alu(mem_alu),
      .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_load(wb_load),
      .wb_alu(wb_alu), .wb_ldata(wb_ldata),
      .val(src_out[g])
    );
  end

  assign opnd_a  = src_out[0];
  assign opnd_b  = src_out[1];
  assign zt_zero = (src_out[0] == '0);

  fwd_store_sel #(.XLEN(XLEN), .RIDX(RIDX)) u_st (
    .clk(clk), .rst(rst),
    .mem_store(mem_store), .mem_rs2(mem_rs2), .mem_sdata(mem_sdata),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_load(wb_load), .wb_ldata(wb_ldata),
    .st_data(st_data)
  );

  fwd_loaduse_det #(.RIDX(RIDX)) u_lu (
    .clk(clk), .rst(rst),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
    .id_store(id_store), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .hazard(hazard)
  );

  assign hold = hazard;
  assign kill = hazard;

  always_ff @(posedge clk) begin
    if (rst) ex_bubble <= 1'b0;
    else     ex_bubble <= hazard;
  end

  // R11
  bubble_follows_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> ex_bubble);
  // R7
  single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !hold);
  // R11 input assumption: inserted no-op never writes
  bubble_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ex_bubble |-> !ex_wen);
endmodule

// File: tb/test_fwd_hazard_unit.sv
module test_fwd_hazard_unit;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [RIDX-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
  logic id_use1, id_use2, id_store, ex_wen, ex_load, mem_store, mem_wen, mem_load, wb_wen, wb_load;
  logic [XLEN-1:0] ex_a, ex_b, mem_alu, mem_sdata, wb_alu, wb_ldata;
  logic [XLEN-1:0] opnd_a, opnd_b, st_data;
  logic zt_zero, hold, kill, ex_bubble;

  fwd_hazard_unit #(.XLEN(XLEN), .RIDX(RIDX)) i_fwd_hazard_unit (
    .clk(clk), .rst(rst),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2), .id_store(id_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .ex_a(ex_a), .ex_b(ex_b),
    .mem_rs2(mem_rs2), .mem_store(mem_store), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .mem_load(mem_load), .mem_alu(mem_alu), .mem_sdata(mem_sdata),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_load(wb_load), .wb_alu(wb_alu), .wb_ldata(wb_ldata),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .zt_zero(zt_zero), .st_data(st_data),
    .hold(hold), .kill(kill), .ex_bubble(ex_bubble)
  );

  typedef struct {
    logic [XLEN-1:0] a, b, sd;
    logic zt, st, bub;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int total = 0;
  int bad = 0;
  logic last_stall = 1'b0;
  bit finished = 1'b0;

  task automatic check(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    id_rs1 = '0; id_rs2 = '0; id_use1 = 0; id_use2 = 0; id_store = 0;
    ex_rs1 = 5'd30; ex_rs2 = 5'd31; ex_rd = '0; ex_wen = 0; ex_load = 0;
    ex_a = 32'h11; ex_b = 32'h22;
    mem_rs2 = '0; mem_store = 0; mem_rd = '0; mem_wen = 0; mem_load = 0;
    mem_alu = 32'hA0; mem_sdata = 32'h5D;
    wb_rd = '0; wb_wen = 0; wb_load = 0; wb_alu = 32'hB0; wb_ldata = 32'hC0;
  endtask

  task automatic push(string tag, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                      logic [XLEN-1:0] sd, logic st);
    exp_t e;
    e.a = a; e.b = b; e.sd = sd; e.zt = (a == '0); e.st = st;
    e.bub = last_stall; e.tag = tag;
    last_stall = st;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "opnd_a", opnd_a, e.a);
        check(e.tag, "opnd_b", opnd_b, e.b);
        check(e.tag, "zt_zero", {31'd0, zt_zero}, {31'd0, e.zt});
        check(e.tag, "st_data", st_data, e.sd);
        check(e.tag, "hold", {31'd0, hold}, {31'd0, e.st});
        check(e.tag, "kill", {31'd0, kill}, {31'd0, e.st});
        check(e.tag, "ex_bubble", {31'd0, ex_bubble}, {31'd0, e.bub});
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state, no matches
    idle(); push("R11 reset", 32'h11, 32'h22, 32'h5D, 0);
    // R1 both operands from execute/memory ALU result
    idle(); ex_rs1 = 3; ex_rs2 = 3; mem_rd = 3; mem_wen = 1; mem_alu = 100;
    push("R1", 100, 100, 32'h5D, 0);
    // R2 writeback ALU result and loaded data
    idle(); ex_rs1 = 6; wb_rd = 6; wb_wen = 1; wb_alu = 200;
    push("R2 alu", 200, 32'h22, 32'h5D, 0);
    idle(); ex_rs2 = 6; wb_rd = 6; wb_wen = 1; wb_load = 1; wb_ldata = 300;
    push("R2 load", 32'h11, 300, 32'h5D, 0);
    // R3 younger stage wins
    idle(); ex_rs1 = 3; mem_rd = 3; mem_wen = 1; mem_alu = 7; wb_rd = 3; wb_wen = 1; wb_alu = 9;
    push("R3 younger", 7, 32'h22, 32'h5D, 0);
    // R3 younger load masks older writeback value
    idle(); ex_rs2 = 4; mem_rd = 4; mem_wen = 1; mem_load = 1; wb_rd = 4; wb_wen = 1; wb_alu = 9;
    push("R3 mask", 32'h11, 32'h22, 32'h5D, 0);
    // R4 register 0 never forwarded
    idle(); ex_rs1 = 0; ex_a = 0; mem_rd = 0; mem_wen = 1; mem_alu = 55; wb_rd = 0; wb_wen = 1;
    push("R4", 0, 32'h22, 32'h5D, 0);
    // R5 disabled write enable
    idle(); ex_rs1 = 8; ex_rs2 = 9; mem_rd = 8; wb_rd = 9;
    push("R5", 32'h11, 32'h22, 32'h5D, 0);
    // R6 zero test on forwarded zero and forwarded nonzero
    idle(); ex_rs1 = 2; ex_a = 9; mem_rd = 2; mem_wen = 1; mem_alu = 0;
    push("R6 zero", 0, 32'h22, 32'h5D, 0);
    idle(); ex_rs1 = 2; ex_a = 0; wb_rd = 2; wb_wen = 1; wb_alu = 4;
    push("R6 nonzero", 4, 32'h22, 32'h5D, 0);
    // R7 load-use stall, then bubble cycle with load moved on (R10, R11)
    idle(); id_rs1 = 8; id_use1 = 1; ex_rd = 8; ex_wen = 1; ex_load = 1;
    push("R7 stall", 32'h11, 32'h22, 32'h5D, 1);
    idle(); id_rs1 = 8; id_use1 = 1; mem_rd = 8; mem_wen = 1; mem_load = 1;
    push("R10 load in mem", 32'h11, 32'h22, 32'h5D, 0);
    // R7 no stall when the source is unused
    idle(); id_rs1 = 8; id_use1 = 0; ex_rd = 8; ex_wen = 1; ex_load = 1;
    push("R7 unused", 32'h11, 32'h22, 32'h5D, 0);
    // R7 second source also triggers
    idle(); id_rs2 = 8; id_use2 = 1; ex_rd = 8; ex_wen = 1; ex_load = 1;
    push("R7 rs2", 32'h11, 32'h22, 32'h5D, 1);
    idle(); push("R11 bubble", 32'h11, 32'h22, 32'h5D, 0);
    // R7 load to register 0 never stalls
    idle(); id_rs1 = 0; id_use1 = 1; ex_rd = 0; ex_wen = 1; ex_load = 1;
    push("R7 r0", 32'h11, 32'h22, 32'h5D, 0);
    // R8 store whose data is the loaded value: no stall
    idle(); id_store = 1; id_rs2 = 8; id_use2 = 1; id_rs1 = 4; id_use1 = 1;
    ex_rd = 8; ex_wen = 1; ex_load = 1;
    push("R8 exempt", 32'h11, 32'h22, 32'h5D, 0);
    // R8 store address from the load: stall
    idle(); id_store = 1; id_rs1 = 8; id_use1 = 1; id_rs2 = 5; id_use2 = 1;
    ex_rd = 8; ex_wen = 1; ex_load = 1;
    push("R8 addr", 32'h11, 32'h22, 32'h5D, 1);
    idle(); push("R11 bubble2", 32'h11, 32'h22, 32'h5D, 0);
    // R9 loaded data to store data
    idle(); mem_store = 1; mem_rs2 = 8; mem_sdata = 1; wb_rd = 8; wb_wen = 1; wb_load = 1; wb_ldata = 77;
    push("R9 ld-st", 32'h11, 32'h22, 77, 0);
    idle(); mem_store = 1; mem_rs2 = 8; mem_sdata = 1; wb_rd = 8; wb_wen = 1; wb_load = 0; wb_ldata = 77;
    push("R9 not load", 32'h11, 32'h22, 1, 0);
    idle(); mem_store = 1; mem_rs2 = 0; mem_sdata = 1; wb_rd = 0; wb_wen = 1; wb_load = 1; wb_ldata = 77;
    push("R9 r0", 32'h11, 32'h22, 1, 0);
    idle(); mem_store = 0; mem_rs2 = 8; mem_sdata = 1; wb_rd = 8; wb_wen = 1; wb_load = 1; wb_ldata = 77;
    push("R9 no store", 32'h11, 32'h22, 1, 0);
    // R10 load in writeback matching decode source
    idle(); id_rs1 = 6; id_use1 = 1; wb_rd = 6; wb_wen = 1; wb_load = 1;
    push("R10 load in wb", 32'h11, 32'h22, 32'h5D, 0);
    idle();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule